// File: doc/BRIEF.md
# Programmable Countdown Interrupt Timer

This block is a 32-bit down-counter that raises an interrupt request when it runs out. Software programs it through a small word-wide register port: a start value, a divider setting that slows the count relative to the core clock, and a timer control entry holding the interrupt vector, a mask flag and a mode flag. The live count can be read back at any time without disturbing it.

In one-shot mode the counter steps down once per divided tick, stops at zero and fires a single time. In periodic mode it reloads the start value on each wrap and fires again, so the spacing between interrupts is the start value plus one, in divided ticks. A masked entry keeps the counter moving but suppresses every interrupt. The divider is fed by a free-running prescaler, so only the tick spacing, not its phase, is fixed by the divider setting.

Top module: `irq_countdown_timer`

## Requirements
- R1: After reset the control entry reads 0x0001_0000 (masked, one-shot, vector 0), the divider reads 0, the start value and the live count read 0, and irq_valid is low.
- R2: Register addresses: 0 start value (read/write), 1 live count (read-only, writes ignored), 2 divider, 3 control entry. The divider keeps only bits 3, 1 and 0 (readback mask 0x0000_000B); the code is {bit3, bit1, bit0}, the prescaler shift is (code + 1) mod 8, so a written 0xB divides by 1, 0x0 by 2, 0x3 by 16 and 0x8 by 32.
- R3: Writing start value N loads the live count with N on that clock edge; afterwards the count drops by one on every divided tick, and reads at address 1 return the live value without changing it.
- R4: In one-shot mode (control bit 17 = 0) the interrupt fires once, N + 1 divided ticks after the start write; the count then stays at 0 and no further interrupt follows.
- R5: In periodic mode (control bit 17 = 1) the count reloads N at each wrap and an interrupt fires every N + 1 divided ticks; with a start value of 0 no interrupt is ever produced.
- R6: While control bit 16 (mask) is set no interrupt is produced but the count keeps moving; clearing the mask in periodic mode resumes interrupts at the next wrap, while a one-shot expiry that passed while masked is not delivered afterwards.
- R7: Each expiry produces irq_valid high for exactly one clock, with irq_vector equal to control bits 7:0 at the moment of expiry.
- R8: Writing the start value while counting restarts the count from the new value; the earlier pending expiry is dropped.
- R9: The control entry keeps only bits 17, 16 and 7:0; its other bits read back as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Register write strobe, sampled on the rising edge |
| addr | input | 2 | Register select for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the selected register (combinational) |
| irq_valid | output | 1 | One-clock interrupt request pulse |
| irq_vector | output | 8 | Vector accompanying irq_valid |

## Verification
The bound checker watches on every cycle that the live count steps down by exactly one per divided tick, holds still once a one-shot run has ended, and that each pulse lasts one clock, carries the vector held just before it, never follows a masked entry and never comes from a periodic entry with a zero start value. Exact firing cycles, the reload cadence, the lost one-shot expiry after unmasking, restart on a rewritten start value and the actual divide ratios depend on sequences of register writes, so only the bench scenarios show them, the divide ratios being measured as spacing between consecutive periodic pulses.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int unsigned REG_ADDR_W = 2;
  localparam int unsigned ENT_PERIODIC_BIT = 17;
  localparam int unsigned ENT_MASK_BIT = 16;
  localparam int unsigned DIV_HI_BIT = 3;

  typedef enum logic [REG_ADDR_W-1:0] {
    ADDR_START = 2'd0,
    ADDR_LIVE  = 2'd1,
    ADDR_DIV   = 2'd2,
    ADDR_CTRL  = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic       periodic;
    logic       masked;
    logic [7:0] vector;
  } ctrl_entry_t;

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CODE_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0]     wdata,
  input  logic [DATA_W-1:0]     live_count,
  output logic [DATA_W-1:0]     rdata,
  output logic [DATA_W-1:0]     start_q,
  output logic [CODE_W-1:0]     div_code,
  output ctrl_entry_t           ctrl_q,
  output logic                  start_load
);

  localparam ctrl_entry_t CTRL_RST = '{periodic: 1'b0, masked: 1'b1, vector: 8'h00};

  logic        start_en, div_en, ctrl_en;
  logic [DATA_W-1:0] start_d;
  logic [CODE_W-1:0] div_d, div_q;
  ctrl_entry_t ctrl_d;

  // write decode
  always_comb begin
    start_en = wr_en && (addr == ADDR_START);
    div_en   = wr_en && (addr == ADDR_DIV);
    ctrl_en  = wr_en && (addr == ADDR_CTRL);
    start_d  = wdata;
    div_d    = {wdata[DIV_HI_BIT], wdata[CODE_W-2:0]};
    ctrl_d.periodic = wdata[ENT_PERIODIC_BIT];
    ctrl_d.masked   = wdata[ENT_MASK_BIT];
    ctrl_d.vector   = wdata[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      div_q   <= '0;
      ctrl_q  <= CTRL_RST;
    end else begin
      if (start_en) start_q <= start_d;
      if (div_en)   div_q   <= div_d;
      if (ctrl_en)  ctrl_q  <= ctrl_d;
    end
  end

  assign start_load = start_en;
  assign div_code   = div_q;

  // readback mux
  always_comb begin
    rdata = '0;
    unique case (addr)
      ADDR_START: rdata = start_q;
      ADDR_LIVE:  rdata = live_count;
      ADDR_DIV: begin
        rdata[DIV_HI_BIT]   = div_q[CODE_W-1];
        rdata[CODE_W-2:0]   = div_q[CODE_W-2:0];
      end
      ADDR_CTRL: begin
        rdata[ENT_PERIODIC_BIT] = ctrl_q.periodic;
        rdata[ENT_MASK_BIT]     = ctrl_q.masked;
        rdata[7:0]              = ctrl_q.vector;
      end
      default: rdata = '0;
    endcase
  end

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] div_code,
  output logic              tick
);

  localparam int unsigned PRE_W = (1 << CODE_W) - 1;

  logic [PRE_W-1:0]  pre_q, pre_d;
  logic [PRE_W-1:0]  low_mask;
  logic [CODE_W-1:0] shift;

  assign shift = div_code + 1'b1;  // wraps, so the all-ones code gives shift 0

  always_comb pre_d = pre_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  for (genvar i = 0; i < PRE_W; i++) begin : g_low_mask
    assign low_mask[i] = (int'(shift) > i);
  end

  // carry out of bit shift-1; with shift 0 the mask is empty and tick is constant high
  assign tick = &(pre_q | ~low_mask);

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             periodic,
  input  logic             masked,
  input  logic [VEC_W-1:0] vector,
  output logic [CNT_W-1:0] count_q,
  output logic             running_q,
  output logic             irq_valid,
  output logic [VEC_W-1:0] irq_vector
);

  logic [CNT_W-1:0] count_d;
  logic             running_d;
  logic             expire;
  logic             irq_d;
  logic [VEC_W-1:0] vec_d;

  always_comb begin
    count_d   = count_q;
    running_d = running_q;
    expire    = 1'b0;
    if (load) begin
      count_d   = load_val;
      running_d = 1'b1;
    end else if (running_q && tick) begin
      if (count_q != '0) begin
        count_d = count_q - 1'b1;
      end else if (periodic) begin
        if (reload_val != '0) begin
          count_d = reload_val;
          expire  = 1'b1;
        end else begin
          running_d = 1'b0;
        end
      end else begin
        running_d = 1'b0;
        expire    = 1'b1;
      end
    end
    irq_d = expire && !masked;
    vec_d = irq_d ? vector : irq_vector;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q    <= '0;
      running_q  <= 1'b0;
      irq_valid  <= 1'b0;
      irq_vector <= '0;
    end else begin
      count_q    <= count_d;
      running_q  <= running_d;
      irq_valid  <= irq_d;
      irq_vector <= vec_d;
    end
  end

endmodule

// File: rtl/irq_countdown_timer.sv
module irq_countdown_timer
  import tmr_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CODE_W = 3,
  parameter int unsigned VEC_W  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0]     wdata,
  output logic [DATA_W-1:0]     rdata,
  output logic                  irq_valid,
  output logic [VEC_W-1:0]      irq_vector
);

  logic [1:0]        rst_sync_q;
  logic              rst_n_int;
  logic [DATA_W-1:0] live_w;
  logic [DATA_W-1:0] start_w;
  logic [CODE_W-1:0] code_w;
  ctrl_entry_t       ctrl_w;
  logic              load_w;
  logic              tick_w;
  logic              running_w;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  tmr_regs #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .live_count (live_w),
    .rdata      (rdata),
    .start_q    (start_w),
    .div_code   (code_w),
    .ctrl_q     (ctrl_w),
    .start_load (load_w)
  );

  tmr_prescaler #(.CODE_W(CODE_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .div_code (code_w),
    .tick     (tick_w)
  );

  tmr_counter #(.CNT_W(DATA_W), .VEC_W(VEC_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .tick       (tick_w),
    .load       (load_w),
    .load_val   (wdata),
    .reload_val (start_w),
    .periodic   (ctrl_w.periodic),
    .masked     (ctrl_w.masked),
    .vector     (ctrl_w.vector),
    .count_q    (live_w),
    .running_q  (running_w),
    .irq_valid  (irq_valid),
    .irq_vector (irq_vector)
  );

endmodule

// File: rtl/irq_countdown_timer_chk.sv
module irq_countdown_timer_chk #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned VEC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load,
  input logic             tick,
  input logic             running,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] start_val,
  input logic             periodic,
  input logic             masked,
  input logic [VEC_W-1:0] vector,
  input logic             irq_valid,
  input logic [VEC_W-1:0] irq_vector
);

  // R3: one step down per divided tick while counting
  p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (running && tick && (count != '0) && !load) |=> (count == $past(count) - 1'b1));

  // R4: an ended run leaves the count alone until the next start write
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !load) |=> $stable(count));

  // R5: a periodic entry with a zero start value never fires
  p_zero_period_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> !($past(periodic) && ($past(start_val) == '0)));

  // R6: no pulse from a masked entry
  p_mask_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> !$past(masked));

  // R7: pulse lasts one clock
  p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |=> !irq_valid);

  // R7: vector taken from the entry at expiry
  p_vector_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_vector == $past(vector)));

endmodule

bind irq_countdown_timer irq_countdown_timer_chk #(.CNT_W(DATA_W), .VEC_W(VEC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n_int),
  .load       (load_w),
  .tick       (tick_w),
  .running    (running_w),
  .count      (live_w),
  .start_val  (start_w),
  .periodic   (ctrl_w.periodic),
  .masked     (ctrl_w.masked),
  .vector     (ctrl_w.vector),
  .irq_valid  (irq_valid),
  .irq_vector (irq_vector)
);

// File: tb/irq_countdown_timer_test.sv
`timescale 1ns/100ps
module irq_countdown_timer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd1;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_valid;
  logic [7:0]  irq_vector;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int pulses = 0;
  bit measure = 1'b0;
  int m_count = 0, m_prev = 0, m_last = 0;
  bit prev_valid = 1'b0;
  int exp_cyc[$];
  logic [7:0] exp_vec[$];

  always #2.5 clk = ~clk;   // 200 MHz

  irq_countdown_timer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq_valid(irq_valid), .irq_vector(irq_vector)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // monitor: pops expected pulses and compares
  always @(negedge clk) begin
    if (rst_n) begin
      if (irq_valid && prev_valid) check("R7 pulse width", 32'd2, 32'd1);
      prev_valid = irq_valid;
      if (irq_valid) begin
        pulses++;
        if (measure) begin
          m_prev = m_last; m_last = cyc; m_count++;
        end else if (exp_cyc.size() == 0) begin
          check("R4/R5/R6 unexpected pulse", 32'(cyc), 32'hFFFF_FFFF);
        end else begin
          check("R4/R5 pulse cycle", 32'(cyc), 32'(exp_cyc.pop_front()));
          check("R7 pulse vector", {24'b0, irq_vector}, {24'b0, exp_vec.pop_front()});
        end
      end
      if (!measure && exp_cyc.size() != 0 && exp_cyc[0] < cyc) begin
        check("R4/R5 missing pulse", 32'hFFFF_FFFF, 32'(exp_cyc.pop_front()));
        void'(exp_vec.pop_front());
      end
    end
  end

  task automatic push(input int c, input logic [7:0] v);
    exp_cyc.push_back(c);
    exp_vec.push_back(v);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, output int w);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1;
    w = cyc;
    wr_en = 1'b0; addr = 2'd1;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d, output int c);
    @(negedge clk);
    addr = a;
    #1;
    d = rdata;
    c = cyc;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  function automatic logic [31:0] oneshot_val(input int n, input int el);
    return (el >= n) ? 32'd0 : 32'(n - el);
  endfunction

  task automatic measure_gap(input logic [31:0] div, input logic [31:0] n, input int exp_gap, input string req);
    int w, t;
    wr(2'd2, div, w);
    wr(2'd0, n, w);
    m_count = 0;
    t = cyc + 4000;
    while (m_count < 3 && cyc < t) @(negedge clk);
    check(req, 32'(m_last - m_prev), 32'(exp_gap));
  endtask

  initial begin : watchdog
    #(150000 * 5);
    errors++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stimulus
    int w, w2, c, u, nxt, p0;
    logic [31:0] d;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    check("R1 irq_valid", {31'b0, irq_valid}, 32'd0);
    rd(2'd3, d, c); check("R1 ctrl entry", d, 32'h0001_0000);
    rd(2'd2, d, c); check("R1 divider", d, 32'd0);
    rd(2'd0, d, c); check("R1 start value", d, 32'd0);
    rd(2'd1, d, c); check("R1 live count", d, 32'd0);

    // R9 / R2 field masking
    wr(2'd3, 32'hFFFF_FFFF, w);
    rd(2'd3, d, c); check("R9 ctrl readback", d, 32'h0003_00FF);
    wr(2'd2, 32'hFFFF_FFFF, w);
    rd(2'd2, d, c); check("R2 divider readback", d, 32'h0000_000B);
    wr(2'd2, 32'h0000_000B, w);

    // R2 / R3 live count is read-only, moves with tick
    wr(2'd3, 32'h0001_0000, w);
    wr(2'd0, 32'd100, w);
    wr(2'd1, 32'd5, u);
    rd(2'd1, d, c); check("R2 live write ignored", d, oneshot_val(100, c - w));
    rd(2'd0, d, c); check("R3 start readback", d, 32'd100);

    // R4 one-shot
    wr(2'd3, 32'h0000_0031, w);
    wr(2'd0, 32'd5, w);
    push(w + 6, 8'h31);
    rd(2'd1, d, c); check("R3 live count step", d, oneshot_val(5, c - w));
    rd(2'd1, d, c); check("R3 live count step again", d, oneshot_val(5, c - w));
    wait_until(w + 20);
    rd(2'd1, d, c); check("R4 count saturates", d, 32'd0);
    check("R4 single expiry", 32'(exp_cyc.size()), 32'd0);

    // R5 periodic, then R6 mask and unmask
    wr(2'd3, 32'h0002_0044, w);
    wr(2'd0, 32'd3, w);
    push(w + 4, 8'h44); push(w + 8, 8'h44); push(w + 12, 8'h44);
    wait_until(w + 13);
    wr(2'd3, 32'h0003_0044, u);
    rd(2'd1, d, c); check("R5 reload cadence", d, 32'(3 - ((c - w) % 4)));
    wait_until(w + 22);
    rd(2'd1, d, c); check("R6 count moves while masked", d, 32'(3 - ((c - w) % 4)));
    wr(2'd3, 32'h0002_0055, u);
    nxt = w + 4 * ((u - w) / 4 + 1);
    push(nxt, 8'h55); push(nxt + 4, 8'h55);
    wait_until(nxt + 5);
    wr(2'd3, 32'h0003_0055, u);
    check("R6 resumed pulses seen", 32'(exp_cyc.size()), 32'd0);

    // R5 zero start value in periodic mode
    wr(2'd3, 32'h0002_0066, w);
    wr(2'd0, 32'd0, w);
    p0 = pulses;
    wait_until(w + 20);
    rd(2'd1, d, c); check("R5 zero start count", d, 32'd0);
    check("R5 zero start no pulse", 32'(pulses - p0), 32'd0);

    // R8 restart by rewriting start value
    wr(2'd3, 32'h0000_0077, w);
    wr(2'd0, 32'd10, w);
    wait_until(w + 4);
    wr(2'd0, 32'd10, w2);
    push(w2 + 11, 8'h77);
    rd(2'd1, d, c); check("R8 restart count", d, oneshot_val(10, c - w2));
    wait_until(w2 + 15);
    check("R8 only restarted expiry", 32'(exp_cyc.size()), 32'd0);

    // R6 one-shot expiry lost while masked
    wr(2'd3, 32'h0001_0088, w);
    wr(2'd0, 32'd2, w);
    wait_until(w + 8);
    rd(2'd1, d, c); check("R6 masked one-shot ran out", d, 32'd0);
    p0 = pulses;
    wr(2'd3, 32'h0000_0088, u);
    wait_until(u + 10);
    check("R6 no late one-shot pulse", 32'(pulses - p0), 32'd0);

    // R2 divide ratios measured as periodic spacing
    wr(2'd3, 32'h0002_0099, w);
    measure = 1'b1;
    measure_gap(32'h0000_0000, 32'd3, 8,  "R2 divide by 2");
    measure_gap(32'h0000_0003, 32'd2, 48, "R2 divide by 16");
    measure_gap(32'h0000_0008, 32'd1, 64, "R2 divide by 32");
    measure_gap(32'h0000_000B, 32'd4, 5,  "R2 divide by 1");
    wr(2'd3, 32'h0003_0099, w);
    repeat (3) @(negedge clk);
    measure = 1'b0;
    repeat (200) @(negedge clk);
    check("R6 no pulse after final mask", 32'(exp_cyc.size()), 32'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule